// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Serial Front End

This block is the digital front end of a two-channel 8-bit DAC. A host sends a 16-bit word while an active-low select is held low. The word has a control byte first and a data byte second. The serial clock, the select, the data line and an active-low load strobe are treated as inputs synchronous to the system clock. The block finds their edges by comparing each input with its value in the previous cycle.

Each channel has two registers: an input register and a DAC register. The DAC register is the value that reaches the converter. A word is accepted only if exactly 16 serial clock rising edges were seen while the select was low. When such a word ends, the data byte is written into the input register of each selected channel.

Each control bit acts on its own, with no decoding. Depending on two of these bits, the accepted word does one of three things to the DAC registers: moves both input registers into them at once, leaves them for a later load-strobe falling edge, or leaves them alone. A falling edge of the load strobe always copies both input registers into the DAC registers, whatever the select is doing. One further control bit sets or clears the power-down flag.

Top module: `dac_serial_if`

## Requirements
- R1: After reset, `dac_a`, `dac_b` and `pwr_dn` are all zero, and both input registers are also zero.
- R2: Serial data is shifted in on each rising edge of `sclk` while `cs_n` is low. The word is sent in this order: three ignored bits, then C2, C1, C0, A1, A0, then the data byte. At the rising edge of `cs_n`, A0=1 writes the data byte into input register A and A1=1 writes it into input register B. When both are set, both input registers get the same byte.
- R3: An accepted word with C1=1 and C0=0 copies both input registers, including the value just written, into the DAC registers at the rising edge of `cs_n`.
- R4: An accepted word with C1=0 updates only the input registers and leaves `dac_a` and `dac_b` unchanged.
- R5: An accepted word with C1=1 and C0=1 leaves the DAC registers unchanged at the rising edge of `cs_n`. Both DAC registers then take their input register values on the next falling edge of `ld_n`.
- R6: Every falling edge of `ld_n` copies both input registers into the DAC registers, with or without a preceding word.
- R7: An accepted word sets `pwr_dn` to the value of C2 (1 means powered down, 0 means powered up). `pwr_dn` changes at no other time.
- R8: The three leading bits of the control byte have no effect on any output.
- R9: A frame with any number of `sclk` rising edges other than 16 (for example 15 or 17) is discarded. It changes neither the input registers, the DAC registers nor `pwr_dn`.
- R10: The data byte is sent MSB first: the 9th bit of the word is D7 and the 16th bit is D0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears all state |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| ld_n | input | 1 | Active-low load strobe; its falling edge copies the input registers into the DAC registers |
| dac_a | output | 8 | DAC register of channel A |
| dac_b | output | 8 | DAC register of channel B |
| pwr_dn | output | 1 | Power-down flag |

## Verification
Words are sent with each address pattern: A only, B only, both, and neither. Because the two channels end up holding different values, a swapped or merged address bit shows up at the outputs. The update bits are tried in all three modes. Each mode is followed by a load-strobe pulse, so a write with C1=0 into the input registers can be seen, and a deferred load can be told apart from an immediate one. Data bytes 0x80 and 0x01 tell MSB-first order from LSB-first order. Frames of 15 and 17 bits, and a word with all three ignored bits set, confirm that the frame length check and the ignored bits leave the stored state alone.

// File: rtl/dac_serial_if.sv
module dac_serial_if #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          sdi,
  input  logic          ld_n,
  output logic [DW-1:0] dac_a,
  output logic [DW-1:0] dac_b,
  output logic          pwr_dn
);
  localparam int CW   = 8;
  localparam int FW   = CW + DW;
  localparam int KW   = FW - 3;
  localparam int CNTW = $clog2(FW + 2);

  logic            cs_q, sclk_q, ld_q;
  logic [KW-1:0]   sh;
  logic [CNTW-1:0] cnt;
  logic [DW-1:0]   in_a, in_b;

  wire shift_en  = !cs_n && sclk && !sclk_q;
  wire frame_end = cs_n && !cs_q;
  wire ld_fall   = !ld_n && ld_q;
  wire word_ok   = frame_end && (cnt == CNTW'(FW));

  wire          c2  = sh[KW-1];
  wire          c1  = sh[KW-2];
  wire          c0  = sh[KW-3];
  wire          a1  = sh[KW-4];
  wire          a0  = sh[KW-5];
  wire [DW-1:0] dat = sh[DW-1:0];

  wire [DW-1:0] nxt_a = (word_ok && a0) ? dat : in_a;
  wire [DW-1:0] nxt_b = (word_ok && a1) ? dat : in_b;
  wire          xfer  = ld_fall || (word_ok && c1 && !c0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      ld_q   <= 1'b1;
      sh     <= '0;
      cnt    <= '0;
      in_a   <= '0;
      in_b   <= '0;
      dac_a  <= '0;
      dac_b  <= '0;
      pwr_dn <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      ld_q   <= ld_n;
      if (cs_n)
        cnt <= '0;
      else if (shift_en && cnt != CNTW'(FW + 1))
        cnt <= cnt + 1'b1;
      if (shift_en)
        sh <= {sh[KW-2:0], sdi};
      in_a <= nxt_a;
      in_b <= nxt_b;
      if (xfer) begin
        dac_a <= nxt_a;
        dac_b <= nxt_b;
      end
      if (word_ok)
        pwr_dn <= c2;
    end
  end
endmodule

module dac_serial_if_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ld_n,
  input logic [DW-1:0] dac_a,
  input logic [DW-1:0] dac_b,
  input logic          pwr_dn
);
  logic csq, ldq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csq <= 1'b1;
      ldq <= 1'b1;
    end else begin
      csq <= cs_n;
      ldq <= ld_n;
    end
  end
  wire cs_ev = cs_n && !csq;
  wire ld_ev = !ld_n && ldq;

  a_r3_dac_a_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_a) |-> $past(cs_ev || ld_ev));
  a_r6_dac_b_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_b) |-> $past(cs_ev || ld_ev));
  a_r7_pwr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_dn) |-> $past(cs_ev));
  a_r5_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ld_ev) |=> ($stable(dac_a) && $stable(dac_b) && $stable(pwr_dn)));
endmodule

bind dac_serial_if dac_serial_if_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ld_n(ld_n),
  .dac_a(dac_a), .dac_b(dac_b), .pwr_dn(pwr_dn)
);

// File: tb/tb_dac_serial_if.sv
module tb_dac_serial_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1;
  logic [7:0] dac_a, dac_b;
  logic pwr_dn;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_serial_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .ld_n(ld_n), .dac_a(dac_a), .dac_b(dac_b), .pwr_dn(pwr_dn)
  );

  // {is_ld, ctl, data, exp_a, exp_b, exp_pd}
  localparam logic [33:0] VEC [13] = '{
    {1'b0, 8'h09, 8'h5A, 8'h5A, 8'h00, 1'b0},  // R2 R3 A only
    {1'b0, 8'h0A, 8'hC3, 8'h5A, 8'hC3, 1'b0},  // R2 R3 B only
    {1'b0, 8'h0B, 8'h81, 8'h81, 8'h81, 1'b0},  // R2 both
    {1'b0, 8'h01, 8'h11, 8'h81, 8'h81, 1'b0},  // R4 input only
    {1'b1, 8'h00, 8'h00, 8'h11, 8'h81, 1'b0},  // R6 strobe
    {1'b0, 8'h0E, 8'h3C, 8'h11, 8'h81, 1'b0},  // R5 deferred
    {1'b1, 8'h00, 8'h00, 8'h11, 8'h3C, 1'b0},  // R5 strobe
    {1'b0, 8'h18, 8'h00, 8'h11, 8'h3C, 1'b1},  // R7 power down
    {1'b0, 8'hE9, 8'h77, 8'h77, 8'h3C, 1'b0},  // R8 R7 ignored bits set
    {1'b0, 8'h03, 8'h00, 8'h77, 8'h3C, 1'b0},  // R4 both, no load
    {1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},  // R6 strobe
    {1'b0, 8'h0B, 8'h80, 8'h80, 8'h80, 1'b0},  // R10 msb
    {1'b0, 8'h0B, 8'h01, 8'h01, 8'h01, 1'b0}   // R10 lsb
  };

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    cs_n = 1'b0;
    wait_n(2);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 16) ? w[15-i] : 1'b0;
      sclk = 1'b0;
      wait_n(2);
      sclk = 1'b1;
      wait_n(2);
    end
    sclk = 1'b0;
    wait_n(2);
    cs_n = 1'b1;
    wait_n(3);
  endtask

  task automatic pulse_ld();
    ld_n = 1'b0;
    wait_n(3);
    ld_n = 1'b1;
    wait_n(2);
  endtask

  task automatic check(input string req, input logic [7:0] ea, input logic [7:0] eb,
                       input logic ep);
    checks++;
    if (dac_a !== ea || dac_b !== eb || pwr_dn !== ep) begin
      fails++;
      $display("FAIL %s: got a=%h b=%h pd=%b, expected a=%h b=%h pd=%b",
               req, dac_a, dac_b, pwr_dn, ea, eb, ep);
    end
  endtask

  initial begin
    wait_n(3);
    check("R1", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    wait_n(2);
    pulse_ld();
    check("R1", 8'h00, 8'h00, 1'b0);  // R1 input registers zero

    for (int v = 0; v < 13; v++) begin
      if (VEC[v][33]) pulse_ld();
      else send(VEC[v][32:17], 16);
      check($sformatf("R2-table[%0d]", v), VEC[v][16:9], VEC[v][8:1], VEC[v][0]);
    end

    // R9: 15-bit and 17-bit frames are discarded
    send(16'h1B55, 15);
    check("R9", 8'h01, 8'h01, 1'b0);
    send(16'h1B55, 17);
    check("R9", 8'h01, 8'h01, 1'b0);
    pulse_ld();
    check("R9", 8'h01, 8'h01, 1'b0);

    // R5: deferred update held until strobe
    send(16'h0FAA, 16);
    check("R5", 8'h01, 8'h01, 1'b0);
    wait_n(5);
    check("R5", 8'h01, 8'h01, 1'b0);
    pulse_ld();
    check("R5", 8'hAA, 8'hAA, 1'b0);

    // R1: reset clears everything again
    send(16'h1B42, 16);
    check("R7", 8'h42, 8'h42, 1'b1);
    rst_n = 1'b0;
    wait_n(2);
    check("R1", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    wait_n(2);
    pulse_ld();
    check("R1", 8'h00, 8'h00, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait_n(100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule